// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus (I2C-style signalling). It holds a small byte-addressed storage array and answers like a serial EEPROM. SCL and SDA are sampled on the system clock. The open-drain SDA pin is split into the sensed level `sda_in` and a pull-down enable `sda_oe`. A master selects the slave with a 7-bit device address plus a direction bit. It can then write one byte or a whole page, or read from the current address, from an address it has just set, or as a sequential stream.

Write data does not go to the array while the bytes arrive. It is collected in a page buffer and becomes pending when the master sends a stop. A self-timed programming interval of `TWR_CYCLES` system clocks then begins. Through that interval the slave stays off the bus and acknowledges nothing. At the end of the interval the buffered bytes are copied into the array. A master finds out that programming has finished by sending the device address again and again until it gets an acknowledge.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A start at any point begins a fresh device-address phase. A stop at any point returns the slave to idle with SDA released.
- R2: The first byte after a start holds the device address in bits 7..1, MSB first, and the read (1) / write (0) flag in bit 0. If bits 7..1 equal `DEV_ADDR` and no programming interval is running, the slave pulls SDA low for the ninth clock. Otherwise it leaves SDA released and ignores the bus until the next start.
- R3: In a write, the byte after the device address is the word address, and its low log2(`MEM_BYTES`) bits are used. Each following data byte is acknowledged and placed at the current address. After each byte only the low log2(`PAGE_BYTES`) address bits advance, wrapping inside the page. Extra bytes overwrite earlier ones in that page, and other pages are never touched.
- R4: Collected write data reaches the array only after a stop. It is committed when `TWR_CYCLES` clocks have passed after that stop. A repeated start before any stop throws away the collected data and starts no programming interval.
- R5: While the programming interval runs, every device address is left unacknowledged, whatever its direction bit, and `sda_oe` stays 0.
- R6: After a read address is acknowledged, the slave sends the byte at the current address, MSB first, changing SDA only while SCL is low. It then advances the address by one. The address wraps from the last array byte to byte 0.
- R7: After a read byte, an acknowledge (SDA low) from the master makes the slave send the next byte. A no-acknowledge makes it release SDA and go idle, so no further byte is driven.
- R8: After a write, the current address is one past the last byte written, wrapped inside its page. A current-address read that follows returns that byte.
- R9: After reset `sda_oe` is 0, the current address is 0, and every array byte holds `ERASED`.
- R10: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level from the pin |
| sda_in | input | 1 | Bus data level sensed at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the slave with a 64-byte array, 8-byte pages and a 600-clock programming interval. With an array that small, the wrap from the last byte to byte 0 and the roll-over inside a page each take only a few bus bytes to reach. Because the interval is longer than one device-address byte at the bench's bit rate, the first poll always falls inside the busy window and a later poll always falls after it. The wrong-address, abandoned-write and busy-read cases all use the same setup.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    // Protocol phase of the slave.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } twi_state_e;

endpackage

// File: rtl/twi_bus_sense.sv
module twi_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_p;
        logic                   sda_p;
    } sense_t;

    sense_t sense_d, sense_q;

    always_comb begin
        sense_d        = sense_q;
        sense_d.scl_sh = {sense_q.scl_sh[SYNC_STAGES-2:0], scl_in};
        sense_d.sda_sh = {sense_q.sda_sh[SYNC_STAGES-2:0], sda_in};
        sense_d.scl_p  = sense_q.scl_sh[SYNC_STAGES-1];
        sense_d.sda_p  = sense_q.sda_sh[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '1;
        end else begin
            sense_q <= sense_d;
        end
    end

    assign scl_s     = sense_q.scl_sh[SYNC_STAGES-1];
    assign sda_s     = sense_q.sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~sense_q.scl_p;
    assign scl_fall  = ~scl_s & sense_q.scl_p;
    assign start_det = scl_s & sense_q.scl_p & sense_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & sense_q.scl_p & ~sense_q.sda_p & sda_s;

endmodule

// File: rtl/twi_write_timer.sv
module twi_write_timer #(
    parameter int TWR_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(TWR_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(TWR_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/twi_page_store.sv
module twi_page_store #(
    parameter int         MEM_BYTES  = 256,
    parameter int         PAGE_BYTES = 16,
    parameter logic [7:0] ERASED     = 8'hFF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         wr_en,
    input  logic [$clog2(MEM_BYTES)-1:0] wr_addr,
    input  logic [7:0]                   wr_data,
    input  logic                         commit,
    input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
    output logic [7:0]                   rd_data
);

    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int ROW_W  = ADDR_W - OFF_W;

    logic [7:0]            mem_q [MEM_BYTES];
    logic [7:0]            pg_q  [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;
    logic [ROW_W-1:0]      row_q;

    wire [OFF_W-1:0] wr_off = wr_addr[OFF_W-1:0];

    // One slot of the page buffer per generate iteration.
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pg_q[g]  <= '0;
                vld_q[g] <= 1'b0;
            end else if (clear || commit) begin
                vld_q[g] <= 1'b0;
            end else if (wr_en && wr_off == OFF_W'(g)) begin
                pg_q[g]  <= wr_data;
                vld_q[g] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (wr_en) begin
            row_q <= wr_addr[ADDR_W-1:OFF_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                mem_q[i] <= ERASED;
            end
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (vld_q[i]) begin
                    mem_q[{row_q, OFF_W'(i)}] <= pg_q[i];
                end
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         MEM_BYTES   = 256,
    parameter int         PAGE_BYTES  = 16,
    parameter int         TWR_CYCLES  = 5000,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ERASED      = 8'hFF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);

    import twi_eeprom_pkg::*;

    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int OFF_W  = $clog2(PAGE_BYTES);

    typedef struct packed {
        twi_state_e        state;
        twi_state_e        nxt;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] addr;
        logic              oe;
        logic              pend;
    } slv_t;

    slv_t slv_d, slv_q;

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_busy, wr_done, tmr_start;
    logic       st_clear, st_wr;
    logic [7:0] rd_data;

    twi_bus_sense #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    twi_write_timer #(
        .TWR_CYCLES(TWR_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(tmr_start),
        .busy (wr_busy),
        .done (wr_done)
    );

    twi_page_store #(
        .MEM_BYTES (MEM_BYTES),
        .PAGE_BYTES(PAGE_BYTES),
        .ERASED    (ERASED)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (st_clear),
        .wr_en  (st_wr),
        .wr_addr(slv_q.addr),
        .wr_data(slv_q.sh),
        .commit (wr_done),
        .rd_addr(slv_q.addr),
        .rd_data(rd_data)
    );

    always_comb begin
        slv_d     = slv_q;
        st_clear  = 1'b0;
        st_wr     = 1'b0;
        tmr_start = 1'b0;
        if (start_det) begin
            slv_d.state = ST_DEV;
            slv_d.cnt   = '0;
            slv_d.oe    = 1'b0;
            slv_d.pend  = 1'b0;
            st_clear    = ~wr_busy;
        end else if (stop_det) begin
            slv_d.state = ST_IDLE;
            slv_d.oe    = 1'b0;
            slv_d.pend  = 1'b0;
            tmr_start   = slv_q.pend;
        end else begin
            case (slv_q.state)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise && slv_q.cnt != 4'd8) begin
                        slv_d.sh  = {slv_q.sh[6:0], sda_s};
                        slv_d.cnt = slv_q.cnt + 4'd1;
                    end else if (scl_fall && slv_q.cnt == 4'd8) begin
                        slv_d.cnt = '0;
                        if (slv_q.state == ST_DEV) begin
                            if (slv_q.sh[7:1] == DEV_ADDR && !wr_busy) begin
                                slv_d.oe    = 1'b1;
                                slv_d.state = ST_ACK;
                                slv_d.nxt   = slv_q.sh[0] ? ST_RDATA : ST_WADDR;
                            end else begin
                                slv_d.state = ST_IDLE;
                            end
                        end else if (slv_q.state == ST_WADDR) begin
                            slv_d.addr  = slv_q.sh[ADDR_W-1:0];
                            slv_d.oe    = 1'b1;
                            slv_d.state = ST_ACK;
                            slv_d.nxt   = ST_WDATA;
                        end else begin
                            st_wr       = 1'b1;
                            slv_d.addr  = {slv_q.addr[ADDR_W-1:OFF_W],
                                           OFF_W'(slv_q.addr[OFF_W-1:0] + 1'b1)};
                            slv_d.pend  = 1'b1;
                            slv_d.oe    = 1'b1;
                            slv_d.state = ST_ACK;
                            slv_d.nxt   = ST_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        slv_d.cnt   = '0;
                        slv_d.state = slv_q.nxt;
                        if (slv_q.nxt == ST_RDATA) begin
                            slv_d.sh   = rd_data;
                            slv_d.oe   = ~rd_data[7];
                            slv_d.addr = slv_q.addr + 1'b1;
                        end else begin
                            slv_d.oe = 1'b0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (slv_q.cnt == 4'd7) begin
                            slv_d.oe    = 1'b0;
                            slv_d.cnt   = '0;
                            slv_d.state = ST_RACK;
                        end else begin
                            slv_d.sh  = {slv_q.sh[6:0], 1'b0};
                            slv_d.oe  = ~slv_q.sh[6];
                            slv_d.cnt = slv_q.cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            slv_d.state = ST_IDLE;
                        end else begin
                            slv_d.state = ST_ACK;
                            slv_d.nxt   = ST_RDATA;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slv_q <= '{state: ST_IDLE, nxt: ST_IDLE, default: '0};
        end else begin
            slv_q <= slv_d;
        end
    end

    assign sda_oe = slv_q.oe;

endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe,
    input logic busy,
    input logic start_det,
    input logic stop_det
);

    // R1: a start leaves SDA released
    a_r1_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R1: a stop leaves SDA released
    a_r1_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R4: programming begins only right after a stop
    a_r4_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    // R5: nothing is driven while programming
    a_r5_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R10: the data pin moves only while the clock is low
    a_r10_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .busy     (wr_busy),
    .start_det(start_det),
    .stop_det (stop_det)
);

// File: tb/twi_eeprom_slave_tb.sv
module twi_eeprom_slave_tb;

    localparam logic [6:0] DEV  = 7'h50;
    localparam int         MEMB = 64;
    localparam int         PGB  = 8;
    localparam int         TWR  = 600;
    localparam int         Q    = 8;

    // word address, data byte
    localparam logic [15:0] VEC [6] = '{16'h0311, 16'h1422, 16'h3F33,
                                        16'h0044, 16'h2855, 16'h1F66};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic sda_line;
    assign sda_line = ~(m_low | sda_oe);

    always #10 clk = ~clk;

    twi_eeprom_slave #(
        .DEV_ADDR  (DEV),
        .MEM_BYTES (MEMB),
        .PAGE_BYTES(PGB),
        .TWR_CYCLES(TWR)
    ) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_in(scl),
        .sda_in(sda_line),
        .sda_oe(sda_oe)
    );

    int         total = 0;
    int         bad = 0;
    int         misses;
    int         oe_viol = 0;
    bit         finished = 0;
    logic       last_oe;
    logic [7:0] mdl  [MEMB];
    logic [7:0] wdat [16];
    logic [7:0] rbuf [16];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R10 monitor: data drive must not move while the bench holds SCL high
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && scl) oe_viol++;
        oe_prev <= sda_oe;
    end

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b1; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b0; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; tick(Q);
            scl = 1'b1;    tick(2 * Q);
            scl = 1'b0;    tick(Q);
        end
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl = 1'b0; tick(Q);
        end
        m_low = give_ack; tick(Q);
        scl = 1'b1;       tick(2 * Q);
        scl = 1'b0;       tick(Q);
        m_low = 1'b0;
    endtask

    task automatic write_seq(input int a, input int n);
        bit ack;
        misses = 0;
        bus_start();
        send_byte({DEV, 1'b0}, ack); if (!ack) misses++;
        send_byte(8'(a), ack);       if (!ack) misses++;
        for (int k = 0; k < n; k++) begin
            send_byte(wdat[k], ack); if (!ack) misses++;
        end
        bus_stop();
    endtask

    task automatic read_seq(input int a, input int n);
        bit ack;
        misses = 0;
        bus_start();
        send_byte({DEV, 1'b0}, ack); if (!ack) misses++;
        send_byte(8'(a), ack);       if (!ack) misses++;
        bus_start();
        send_byte({DEV, 1'b1}, ack); if (!ack) misses++;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, rbuf[k]);
        end
        tick(Q);
        last_oe = sda_oe;
        bus_stop();
    endtask

    task automatic poll(output int n);
        bit ack;
        n = 0;
        do begin
            bus_start();
            send_byte({DEV, 1'b0}, ack);
            bus_stop();
            n++;
        end while (!ack && n < 40);
        check("R5 poll eventually acknowledged", 32'(ack), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit         ack;
        int         np;
        logic [7:0] b;
        for (int i = 0; i < MEMB; i++) mdl[i] = 8'hFF;
        tick(5);
        check("R9 sda_oe in reset", 32'(sda_oe), 32'd0);
        rst_n = 1'b1;
        tick(5);
        check("R9 sda_oe after reset", 32'(sda_oe), 32'd0);

        // R9/R6: current-address read right after reset hits byte 0
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        check("R2 read address acknowledged", 32'(ack), 32'd1);
        recv_byte(1'b0, b);
        bus_stop();
        check("R9 erased content at address 0", 32'(b), 32'hFF);

        // R2: wrong device address
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, ack);
        check("R2 mismatched address not acknowledged", 32'(ack), 32'd0);
        bus_stop();

        // Vector table: byte write, poll, random read back
        for (int v = 0; v < 6; v++) begin
            wdat[0] = VEC[v][7:0];
            write_seq(int'(VEC[v][15:8]), 1);
            check("R3 byte write acknowledges", 32'(misses), 32'd0);
            mdl[VEC[v][15:8]] = VEC[v][7:0];
            poll(np);
            check("R5 first poll inside busy window refused", 32'(np > 1), 32'd1);
            read_seq(int'(VEC[v][15:8]), 1);
            check("R4 committed byte reads back", 32'(rbuf[0]), 32'(mdl[VEC[v][15:8]]));
        end

        // R6: wrap from last byte to byte 0
        read_seq(MEMB - 1, 2);
        check("R6 last byte", 32'(rbuf[0]), 32'(mdl[MEMB-1]));
        check("R6 wrap to byte 0", 32'(rbuf[1]), 32'(mdl[0]));

        // R7: NACK ends the read; next byte (0x11 at 3) would pull SDA low
        read_seq(2, 1);
        check("R7 byte before nack", 32'(rbuf[0]), 32'(mdl[2]));
        check("R7 released after nack", 32'(last_oe), 32'd0);

        // R3: page write of 10 bytes from offset 5 of page 1
        for (int k = 0; k < 10; k++) begin
            wdat[k] = 8'hA0 + 8'(k);
            mdl[8 + ((5 + k) % PGB)] = 8'hA0 + 8'(k);
        end
        write_seq(13, 10);
        check("R3 page write acknowledges", 32'(misses), 32'd0);
        poll(np);

        // R8: current address is one past the last byte, inside the page
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b0, b);
        bus_stop();
        check("R8 current address after page write", 32'(b), 32'(mdl[15]));

        // R3/R7: sequential read of the page
        read_seq(8, 8);
        for (int k = 0; k < 8; k++) begin
            check("R3 page content after roll over", 32'(rbuf[k]), 32'(mdl[8 + k]));
        end
        read_seq(16, 1);
        check("R3 next page untouched", 32'(rbuf[0]), 32'(mdl[16]));

        // R4/R1: repeated start abandons a write
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'd20, ack);
        send_byte(8'h99, ack);
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        check("R1 repeated start begins new address phase", 32'(ack), 32'd1);
        send_byte(8'd20, ack);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b0, b);
        bus_stop();
        check("R4 abandoned write leaves old data", 32'(b), 32'(mdl[20]));

        // R5: read address during programming
        wdat[0] = 8'h5A;
        write_seq(40, 1);
        mdl[40] = 8'h5A;
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        bus_stop();
        check("R5 read address refused while busy", 32'(ack), 32'd0);
        poll(np);
        read_seq(40, 1);
        check("R4 byte after busy read attempt", 32'(rbuf[0]), 32'h5A);

        check("R10 sda_oe moved only with SCL low", 32'(oe_viol), 32'd0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule